// File: doc/BRIEF.md
# Vector indexed atomic memory sequencer

This block carries out one vector indexed atomic instruction, element by element. When `start` is pulsed, it captures a scalar base address, one byte offset per element, the destination vector (which also supplies the source operands), a mask vector with its enable, the write-destination flag, the operation code, the element width, and the start and length bounds. It then visits the elements from the start index up to, but not including, the length. For each element that is not masked off it performs an atomic read-modify-write on a simple memory port.

Each atomic access reads the old value and holds the request until read data is valid. It then writes back, in a single write cycle, the combination of the old value and the source element. If the write-destination flag was set, it also returns the old value to the destination vector element. A one-cycle `done` pulse closes the instruction. That pulse is the point at which the surrounding pipeline clears its start index to zero.

An unsupported width or operation code does not run. It raises a one-cycle `illegal` pulse instead.

Top module: `vamo_seq`

## Requirements
- R1: Elements are visited in ascending index order from `vstart` up to `vl`-1. After the last element, `done` is high for exactly one cycle. When `vl` <= `vstart`, no memory access occurs and `done` still pulses.
- R2: The address of element i is `base_addr` plus bits [i*AW +: AW] of `index_vec`, taken modulo 2^AW.
- R3: The `sew` value selects the element width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. `mem_size` equals `sew` during accesses. Any `sew` value of 4 to 7 gives a one-cycle `illegal` pulse, no `done` and no memory access.
- R4: The `op` codes are 0 swap, 1 add, 2 xor, 3 and, 4 or, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max. Codes 9 to 15 are handled as in R3.
- R5: Swap writes the source element. Every other operation writes the old memory value combined with the source. Add wraps modulo 2^width.
- R6: Min and max compare at the element width, as signed values for codes 5 and 6 and as unsigned values for codes 7 and 8. Max keeps the memory value when it is >= the source. Min keeps the memory value only when it is strictly less than the source.
- R7: With `mask_en` = 1, an element whose `mask_vec` bit is 0 gets no memory access and no destination write.
- R8: With `wd_en` = 1, each processed element i produces one `dst_we` cycle with `dst_idx` = i and `dst_wdata` = the old memory value, zero-extended. With `wd_en` = 0, `dst_we` never rises.
- R9: The source for element i is slot i of `dst_vec` (64 bits per slot) as captured at `start`. Later changes to `dst_vec` have no effect.
- R10: A read request holds a stable address until `mem_rvalid` arrives. The write for that element follows in the next cycle and lasts one cycle. No other access comes between the read and the write of an element.
- R11: Memory data uses the low `8<<sew` bits, little-endian. `mem_wdata` bits above the width are 0, so bytes beyond the element stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (ignored while busy) |
| base_addr | input | AW | Scalar base address |
| index_vec | input | NELEM*AW | Per-element byte offsets |
| dst_vec | input | NELEM*64 | Destination vector contents, supplying the source operands |
| mask_vec | input | NELEM | Per-element mask bits |
| mask_en | input | 1 | Masking enable |
| wd_en | input | 1 | Return old values to the destination |
| op | input | 4 | Atomic operation code |
| sew | input | 3 | Element width code |
| vstart | input | CW | First element index |
| vl | input | CW | Vector length (exclusive end) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size code (as in `sew`) |
| mem_wdata | output | 64 | Write data, low-aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, low-aligned |
| dst_we | output | 1 | Destination element write |
| dst_idx | output | EIW | Destination element index |
| dst_wdata | output | 64 | Old value to the destination |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-encoding pulse |

## Verification
Several elements share one address so that each access must see the previous element's result; a design that reordered the elements or overlapped their accesses would leave the wrong sum in memory. Equal and sign-crossing operands at 16 bits separate signed from unsigned comparison and test the tie rule; a design that compared at full 64-bit width, or with the wrong signedness, would store the other operand. An 8-bit add of 0xFF and 1 must wrap to 0 and leave the next byte unchanged; a design that carried into the next byte or wrote a wider access would disturb it. Empty ranges, a mask of all zeros, illegal widths and opcodes, and a `dst_vec` that is scrambled after `start` are also covered; these catch spurious accesses, wrongly raised or missing pulses, and operands read live instead of captured at `start`.

// File: rtl/vamo_pkg.sv
package vamo_pkg;

  localparam int ELEN = 64;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_XOR  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RD,
    ST_WR,
    ST_DONE
  } seq_state_e;

  // mask of the live bits for a width code
  function automatic logic [ELEN-1:0] wmask(input logic [1:0] w);
    case (w)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // left shift that puts the element's sign bit at bit 63
  function automatic logic [5:0] just_shift(input logic [1:0] w);
    case (w)
      2'd0:    return 6'd56;
      2'd1:    return 6'd48;
      2'd2:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [ELEN-1:0] amo_combine(input amo_op_e op,
                                                  input logic [ELEN-1:0] mv,
                                                  input logic [ELEN-1:0] sv,
                                                  input logic [1:0] w);
    logic [ELEN-1:0] ml, sl, r;
    logic s_ge, u_ge;
    ml   = mv << just_shift(w);
    sl   = sv << just_shift(w);
    s_ge = $signed(ml) >= $signed(sl);
    u_ge = ml >= sl;
    case (op)
      OP_SWAP: r = sv;
      OP_ADD:  r = mv + sv;
      OP_XOR:  r = mv ^ sv;
      OP_AND:  r = mv & sv;
      OP_OR:   r = mv | sv;
      OP_MIN:  r = s_ge ? sv : mv;
      OP_MAX:  r = s_ge ? mv : sv;
      OP_MINU: r = u_ge ? sv : mv;
      OP_MAXU: r = u_ge ? mv : sv;
      default: r = sv;
    endcase
    return r & wmask(w);
  endfunction

endpackage

// File: rtl/vamo_alu.sv
module vamo_alu
  import vamo_pkg::*;
(
  input  amo_op_e         op,
  input  logic [1:0]      w,
  input  logic [ELEN-1:0] old_val,
  input  logic [ELEN-1:0] src_val,
  output logic [ELEN-1:0] result
);

  assign result = amo_combine(op, old_val, src_val, w);

endmodule

// File: rtl/vamo_pick.sv
module vamo_pick #(
  parameter int NELEM = 8,
  parameter int CW    = 4,
  parameter int EIW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cursor,
  input  logic [CW-1:0]    bound,
  input  logic [NELEM-1:0] mask,
  input  logic             mask_en,
  output logic             found,
  output logic [EIW-1:0]   pick
);

  logic [NELEM-1:0] cand;

  for (genvar g = 0; g < NELEM; g++) begin : g_cand
    assign cand[g] = (CW'(g) >= cursor) && (CW'(g) < bound) && (!mask_en || mask[g]);
  end

  // lowest candidate wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NELEM - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        pick  = EIW'(i);
      end
    end
  end

  // R1: a chosen element lies inside the remaining window
  p_pick_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (CW'(pick) >= cursor) && (CW'(pick) < bound));

  // R7: a chosen element is never a masked-off one
  p_pick_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (found && mask_en) |-> mask[pick]);

endmodule

// File: rtl/vamo_seq.sv
module vamo_seq
  import vamo_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int AW    = 16,
  localparam int CW   = $clog2(NELEM + 1),
  localparam int EIW  = (NELEM > 1) ? $clog2(NELEM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         base_addr,
  input  logic [NELEM*AW-1:0]   index_vec,
  input  logic [NELEM*ELEN-1:0] dst_vec,
  input  logic [NELEM-1:0]      mask_vec,
  input  logic                  mask_en,
  input  logic                  wd_en,
  input  logic [3:0]            op,
  input  logic [2:0]            sew,
  input  logic [CW-1:0]         vstart,
  input  logic [CW-1:0]         vl,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [1:0]            mem_size,
  output logic [ELEN-1:0]       mem_wdata,
  input  logic                  mem_rvalid,
  input  logic [ELEN-1:0]       mem_rdata,
  output logic                  dst_we,
  output logic [EIW-1:0]        dst_idx,
  output logic [ELEN-1:0]       dst_wdata,
  output logic                  busy,
  output logic                  done,
  output logic                  illegal
);

  seq_state_e                  st;
  logic [AW-1:0]               base_q;
  logic [NELEM-1:0][AW-1:0]    idx_q;
  logic [NELEM-1:0][ELEN-1:0]  src_q;
  logic [NELEM-1:0]            mask_q;
  logic                        men_q;
  logic                        wd_q;
  amo_op_e                     op_q;
  logic [1:0]                  w_q;
  logic [CW-1:0]               vl_q;
  logic [CW-1:0]               cur_q;
  logic [EIW-1:0]              el_q;
  logic [ELEN-1:0]             old_q;
  logic                        illegal_q;

  // named internal events
  logic            enc_legal;
  logic            take_start;
  logic            pick_found;
  logic [EIW-1:0]  pick_idx;
  logic            rd_done;
  logic [ELEN-1:0] alu_res;

  assign enc_legal  = (sew <= 3'd3) && (op <= 4'd8);
  assign take_start = (st == ST_IDLE) && start;
  assign rd_done    = (st == ST_RD) && mem_rvalid;

  vamo_pick #(.NELEM(NELEM), .CW(CW), .EIW(EIW)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .cursor  (cur_q),
    .bound   (vl_q),
    .mask    (mask_q),
    .mask_en (men_q),
    .found   (pick_found),
    .pick    (pick_idx)
  );

  vamo_alu u_alu (
    .op      (op_q),
    .w       (w_q),
    .old_val (old_q),
    .src_val (src_q[el_q]),
    .result  (alu_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      base_q    <= '0;
      idx_q     <= '0;
      src_q     <= '0;
      mask_q    <= '0;
      men_q     <= 1'b0;
      wd_q      <= 1'b0;
      op_q      <= OP_SWAP;
      w_q       <= 2'd0;
      vl_q      <= '0;
      cur_q     <= '0;
      el_q      <= '0;
      old_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take_start) begin
            if (enc_legal) begin
              base_q <= base_addr;
              idx_q  <= index_vec;
              src_q  <= dst_vec;
              mask_q <= mask_vec;
              men_q  <= mask_en;
              wd_q   <= wd_en;
              op_q   <= amo_op_e'(op);
              w_q    <= sew[1:0];
              vl_q   <= vl;
              cur_q  <= vstart;
              st     <= ST_SCAN;
            end else begin
              illegal_q <= 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (pick_found) begin
            el_q <= pick_idx;
            st   <= ST_RD;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_RD: begin
          if (rd_done) begin
            old_q <= mem_rdata & wmask(w_q);
            st    <= ST_WR;
          end
        end
        ST_WR: begin
          cur_q <= CW'(el_q) + CW'(1);
          st    <= ST_SCAN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = base_q + idx_q[el_q];
  assign mem_size  = w_q;
  assign mem_wdata = alu_res;
  assign dst_we    = (st == ST_WR) && wd_q;
  assign dst_idx   = el_q;
  assign dst_wdata = old_q;
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);
  assign illegal   = illegal_q;

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: an illegal encoding starts no run
  p_illegal_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !mem_req);

  // R10: a pending read holds its address
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_rvalid) |=> (mem_req && !mem_we && $stable(mem_addr)));

  // R10: a write is directly preceded by read data
  p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_rvalid));

  // R10: a write lasts one cycle
  p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !mem_we);

  // R8: destination writes only with the flag captured at start
  p_dst_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> wd_q);

  // R11: write data carries nothing above the element width
  p_wdata_narrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_wdata & ~wmask(mem_size)) == '0));

endmodule

// File: tb/sim_vamo_seq.sv
`timescale 1ns/1ps
module sim_vamo_seq;

  localparam int NELEM = 8;
  localparam int AW    = 16;
  localparam int CW    = 4;
  localparam int EIW   = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [AW-1:0]         base_addr = '0;
  logic [NELEM*AW-1:0]   index_vec = '0;
  logic [NELEM*64-1:0]   dst_vec = '0;
  logic [NELEM-1:0]      mask_vec = '0;
  logic                  mask_en = 1'b0;
  logic                  wd_en = 1'b0;
  logic [3:0]            op = '0;
  logic [2:0]            sew = '0;
  logic [CW-1:0]         vstart = '0;
  logic [CW-1:0]         vl = '0;
  logic                  mem_req, mem_we;
  logic [AW-1:0]         mem_addr;
  logic [1:0]            mem_size;
  logic [63:0]           mem_wdata;
  logic                  mem_rvalid = 1'b0;
  logic [63:0]           mem_rdata = '0;
  logic                  dst_we;
  logic [EIW-1:0]        dst_idx;
  logic [63:0]           dst_wdata;
  logic                  busy, done, illegal;

  always #2.5 clk = ~clk;

  vamo_seq #(.NELEM(NELEM), .AW(AW)) u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [7:0]  mem     [256];
  logic [7:0]  exp_mem [256];
  logic [63:0] got_dst [NELEM];
  logic        got_we  [NELEM];
  logic [63:0] exp_dst [NELEM];
  logic        exp_we  [NELEM];
  int          n_reads, n_req, bad_hi, lat;

  // case inputs
  logic [AW-1:0] c_base;
  logic [AW-1:0] c_idx [NELEM];
  logic [63:0]   c_src [NELEM];
  logic [NELEM-1:0] c_mask;
  logic c_men, c_wd;
  logic [3:0] c_op;
  logic [2:0] c_sew;
  int c_vs, c_vl;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] szmask(input int sz);
    return (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [63:0] sx(input logic [63:0] v, input int sz);
    case (sz)
      0: return {{56{v[7]}}, v[7:0]};
      1: return {{48{v[15]}}, v[15:0]};
      2: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  // bench restatement of the operation set
  function automatic logic [63:0] ref_op(input int o, input logic [63:0] m, input logic [63:0] s, input int sz);
    logic [63:0] mz, szv, r;
    longint ms, ss;
    mz = m & szmask(sz); szv = s & szmask(sz);
    ms = longint'(sx(m, sz)); ss = longint'(sx(s, sz));
    case (o)
      0: r = szv;
      1: r = mz + szv;
      2: r = mz ^ szv;
      3: r = mz & szv;
      4: r = mz | szv;
      5: r = (ms < ss) ? mz : szv;
      6: r = (ms >= ss) ? mz : szv;
      7: r = (mz < szv) ? mz : szv;
      default: r = (mz >= szv) ? mz : szv;
    endcase
    return r & szmask(sz);
  endfunction

  function automatic logic [63:0] ld_exp(input logic [AW-1:0] a, input int sz);
    logic [63:0] v = '0;
    for (int k = 0; k < (1 << sz); k++) v[k*8 +: 8] = exp_mem[(int'(a) + k) & 255];
    return v;
  endfunction

  // memory model and observers, all on the falling edge
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 1'b0;
    else if (mem_req && !mem_we) begin
      if (lat == 0) begin
        for (int k = 0; k < 8; k++)
          mem_rdata[k*8 +: 8] = (k < (1 << mem_size)) ? mem[(int'(mem_addr) + k) & 255] : 8'hA5;
        mem_rvalid = 1'b1;
        n_reads++;
        lat = $urandom % 3;
      end else lat--;
    end
    if (mem_req && mem_we) begin
      for (int k = 0; k < (1 << mem_size); k++) mem[(int'(mem_addr) + k) & 255] = mem_wdata[k*8 +: 8];
      if ((mem_wdata & ~szmask(int'(mem_size))) != 0) bad_hi++;
    end
    if (mem_req) n_req++;
    if (dst_we) begin
      got_we[dst_idx]  = 1'b1;
      got_dst[dst_idx] = dst_wdata;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_case(input string tag);
    bit exp_illegal, seen_done, seen_ill;
    int exp_reads, mism, first;
    logic [AW-1:0] a;
    logic [63:0] old;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < NELEM; i++) begin
      got_we[i] = 0; got_dst[i] = '0; exp_we[i] = 0; exp_dst[i] = '0;
    end
    n_reads = 0; n_req = 0; bad_hi = 0; exp_reads = 0;
    exp_illegal = (c_sew > 3) || (c_op > 8);
    if (!exp_illegal) begin
      for (int i = c_vs; i < c_vl; i++) begin
        if (c_men && !c_mask[i]) continue;
        a = c_base + c_idx[i];
        old = ld_exp(a, int'(c_sew));
        old = ref_op(int'(c_op), old, c_src[i], int'(c_sew));
        for (int k = 0; k < (1 << c_sew); k++) exp_mem[(int'(a) + k) & 255] = old[k*8 +: 8];
        if (c_wd) begin exp_we[i] = 1; exp_dst[i] = ld_exp_prev(a, i); end
        exp_reads++;
      end
    end
    @(negedge clk);
    base_addr = c_base;
    for (int i = 0; i < NELEM; i++) begin
      index_vec[i*AW +: AW] = c_idx[i];
      dst_vec[i*64 +: 64]   = c_src[i];
    end
    mask_vec = c_mask; mask_en = c_men; wd_en = c_wd; op = c_op; sew = c_sew;
    vstart = CW'(c_vs); vl = CW'(c_vl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dst_vec = ~dst_vec;  // R9: later changes must not matter
    seen_done = 0; seen_ill = 0;
    for (int t = 0; t < 400; t++) begin
      if (done) seen_done = 1;
      if (illegal) seen_ill = 1;
      if (seen_done || seen_ill) break;
      @(negedge clk);
    end
    if (exp_illegal) begin
      chk(seen_ill && !seen_done, {tag, " R3/R4 illegal pulse"}, {62'd0, seen_done, seen_ill}, 64'd1);
      chk(n_req == 0, {tag, " R3 no access when illegal"}, 64'(n_req), 64'd0);
      return;
    end
    chk(seen_done && !seen_ill, {tag, " R1 done pulse"}, {62'd0, seen_done, seen_ill}, 64'd2);
    @(negedge clk);
    chk(!done, {tag, " R1 done one cycle"}, {63'd0, done}, 64'd0);
    chk(n_reads == exp_reads, {tag, " R1/R7 access count"}, 64'(n_reads), 64'(exp_reads));
    mism = 0; first = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) begin if (mism == 0) first = i; mism++; end
    chk(mism == 0, {tag, " R2/R5/R6 memory"}, {56'd0, mem[first]}, {56'd0, exp_mem[first]});
    mism = 0; first = 0;
    for (int i = 0; i < NELEM; i++)
      if (got_we[i] !== exp_we[i] || (exp_we[i] && got_dst[i] !== exp_dst[i])) begin
        if (mism == 0) first = i; mism++;
      end
    chk(mism == 0, {tag, " R8/R9 destination"}, got_dst[first], exp_dst[first]);
    chk(bad_hi == 0, {tag, " R11 write data width"}, 64'(bad_hi), 64'd0);
  endtask

  // old value of element i: replay the earlier elements from the memory image before the run
  function automatic logic [63:0] ld_exp_prev(input logic [AW-1:0] a, input int upto);
    logic [7:0] img [256];
    logic [AW-1:0] b;
    logic [63:0] v, o;
    for (int i = 0; i < 256; i++) img[i] = mem[i];
    for (int i = c_vs; i < upto; i++) begin
      if (c_men && !c_mask[i]) continue;
      b = c_base + c_idx[i];
      v = '0;
      for (int k = 0; k < (1 << c_sew); k++) v[k*8 +: 8] = img[(int'(b) + k) & 255];
      o = ref_op(int'(c_op), v, c_src[i], int'(c_sew));
      for (int k = 0; k < (1 << c_sew); k++) img[(int'(b) + k) & 255] = o[k*8 +: 8];
    end
    v = '0;
    for (int k = 0; k < (1 << c_sew); k++) v[k*8 +: 8] = img[(int'(a) + k) & 255];
    return v;
  endfunction

  task automatic set_default();
    c_base = 16'h0100; c_mask = '1; c_men = 0; c_wd = 1; c_op = 4'd0; c_sew = 3'd0;
    c_vs = 0; c_vl = 1;
    for (int i = 0; i < NELEM; i++) begin c_idx[i] = AW'(i * 8); c_src[i] = 64'h0; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    lat = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !illegal && !dst_we, "R1 reset state",
        {59'd0, busy, mem_req, done, illegal, dst_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: 8-bit add wraps, neighbour byte untouched
    set_default(); c_op = 4'd1; c_idx[0] = 16'h0010; c_base = 16'h0000; c_src[0] = 64'hFFFF_FFFF_FFFF_FF01;
    mem[16] = 8'hFF; mem[17] = 8'h5A;
    run_case("add wrap e8 R5");
    chk(mem[16] == 8'h00 && mem[17] == 8'h5A, "R5/R11 wrap result", {48'd0, mem[17], mem[16]}, 64'h5A00);

    // R6: signed vs unsigned min/max at 16 bits, sign-crossing operands
    for (int o = 5; o <= 8; o++) begin
      set_default(); c_op = 4'(o); c_sew = 3'd1; c_base = 16'h0040; c_idx[0] = 0;
      mem[64] = 8'h00; mem[65] = 8'h80; c_src[0] = 64'hFFFF_FFFF_FFFF_0001;
      run_case("minmax sign R6");
    end
    // R6: equal operands
    for (int o = 5; o <= 8; o++) begin
      set_default(); c_op = 4'(o); c_sew = 3'd1; c_base = 16'h0040; c_idx[0] = 0;
      mem[64] = 8'h34; mem[65] = 8'h12; c_src[0] = 64'h0000_0000_0000_1234;
      run_case("minmax tie R6");
    end

    // R1/R10: all elements alias one address, accumulate in order
    set_default(); c_op = 4'd1; c_sew = 3'd2; c_vl = NELEM; c_base = 16'h0080;
    for (int i = 0; i < NELEM; i++) begin c_idx[i] = 0; c_src[i] = 64'(i * 3 + 1); end
    run_case("alias add e32 R1");

    // R1: empty ranges
    set_default(); c_vs = 5; c_vl = 2; run_case("vl below vstart R1");
    chk(n_req == 0, "R1 empty range no access", 64'(n_req), 64'd0);
    set_default(); c_vs = 0; c_vl = 0; run_case("vl zero R1");

    // R7: everything masked off
    set_default(); c_men = 1; c_mask = '0; c_vl = NELEM; run_case("all masked R7");
    chk(n_req == 0, "R7 masked no access", 64'(n_req), 64'd0);

    // R8: wd clear, swap at 64 bits
    set_default(); c_wd = 0; c_sew = 3'd3; c_vl = 3; c_vs = 1;
    for (int i = 0; i < NELEM; i++) c_src[i] = {32'($urandom), 32'($urandom)};
    run_case("swap no wd R8");

    // R3/R4: illegal encodings
    set_default(); c_sew = 3'd5; run_case("bad width R3");
    set_default(); c_op = 4'd11; run_case("bad opcode R4");

    // random mix
    for (int n = 0; n < 40; n++) begin
      c_base = 16'($urandom);
      for (int i = 0; i < NELEM; i++) begin
        c_idx[i] = 16'($urandom);
        c_src[i] = {32'($urandom), 32'($urandom)};
      end
      c_mask = NELEM'($urandom); c_men = 1'($urandom); c_wd = 1'($urandom);
      c_op = 4'($urandom % 9); c_sew = 3'($urandom % 4);
      c_vl = $urandom % (NELEM + 1); c_vs = $urandom % (c_vl + 1);
      run_case("random R2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule